// File: doc/BRIEF.md
# System Management Watchdog Timer

This block is a software-serviced watchdog for a board management controller. Software loads an 8-bit timeout into a preset register and chooses a short or a long timebase. It then arms the watchdog through a command bit in the control register. While the watchdog is armed, every tick of the chosen timebase lowers a down-counter. Software must re-arm the watchdog before the count runs out, and each re-arm reloads the count from the preset. The two tick-enable inputs stand in for a 2 s tick and a 60 s tick that are generated elsewhere.

When the count runs out, the watchdog disarms itself and sets a sticky event flag. That flag drives the alarm output and can be read back in the state register. The block then normally sends a fixed-length system-reset pulse. If the power-off option is set and the thermal-event input is high at the moment of expiry, it raises a power-off request instead. That request stays high until the block's own hardware reset.

Register access uses a single-cycle write strobe with an address and write data, plus a read-data bus driven combinationally from the address.

Top module: `smwd_top`

## Requirements
- R1: After reset, the control, state and preset registers read 0x00, and sys_rst_o, power_off_o and wd_alarm_o are low.
- R2: The preset register at address 2 stores all 8 written bits and reads them back unchanged.
- R3: Writing the control register (address 0) with bit 4 set and bit 5 clear arms the watchdog and reloads the count from the preset. Control bit 4 reads 1 while armed. Control bits 7 and 6 read back as written. Bit 5 and bits 3:0 read 0.
- R4: A control write with bit 5 set disarms the watchdog, and this wins over bit 4 in the same write. A disarmed watchdog ignores ticks and never expires.
- R5: Control bit 6 chooses the timebase. With bit 6 = 1 only tick_long_i is counted, and with bit 6 = 0 only tick_short_i is counted. Ticks of the other timebase have no effect.
- R6: With preset N ≥ 1, expiry happens on the N-th counted tick after arming. A preset of 0 expires on the first counted tick. Re-arming before expiry restarts the full count.
- R7: At expiry the watchdog disarms itself, so control bit 4 reads 0 in the next cycle. Further ticks cause no new expiry until it is armed again.
- R8: If expiry happens while control bit 7 is clear or thermal_i is low, sys_rst_o goes high from the clock edge of the expiring tick for exactly RST_CYCLES cycles, and power_off_o stays low.
- R9: If expiry happens while control bit 7 is set and thermal_i is high, power_off_o rises at that clock edge and stays high until rst_n falls. No reset pulse is sent.
- R10: Every expiry sets a sticky flag, seen as state register (address 1) bit 1 and as wd_alarm_o. Writing the state register with bit 1 set clears the flag. Writing it with bit 1 clear leaves the flag as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 state, 2 preset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| tick_short_i | input | 1 | One-cycle tick of the short (2 s) timebase |
| tick_long_i | input | 1 | One-cycle tick of the long (60 s) timebase |
| thermal_i | input | 1 | Thermal event active |
| sys_rst_o | output | 1 | System-reset pulse |
| power_off_o | output | 1 | Held power-off request |
| wd_alarm_o | output | 1 | Watchdog event alarm (sticky flag) |

## Verification
The hardest conditions to reach are the collisions. One is a re-arm that lands during an almost-expired count. Another is expiry under the two action policies with the thermal input sampled exactly at the expiring edge. A third is stray ticks of the timebase that is not selected. The stimulus runs many armed sessions with random presets, random timebase, random power-off option and random thermal level. Before each counted tick it randomly inserts a tick of the wrong timebase. A bench model predicts the expiring tick and the resulting action. Directed cases add a re-arm with a partial count remaining, a combined arm-and-disarm write, a zero preset, and a hardware reset that clears the held power-off request.

// File: rtl/smwd_pkg.sv
package smwd_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL   = 2'd0,
      REG_STATE  = 2'd1,
      REG_PRESET = 2'd2
   } smwd_reg_e;

   // control bit positions
   localparam int CTRL_PWROFF = 7;
   localparam int CTRL_TBLONG = 6;
   localparam int CTRL_STOP   = 5;
   localparam int CTRL_START  = 4;
   // state bit positions
   localparam int STATE_FLAG  = 1;
endpackage

// File: rtl/smwd_regs.sv
module smwd_regs
   import smwd_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              armed_i,
   input  logic              flag_i,
   output logic [CNT_W-1:0]  preset_o,
   output logic              pwroff_en_o,
   output logic              tb_long_o,
   output logic              cmd_start_o,
   output logic              cmd_stop_o,
   output logic              flag_clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic ctrl_wr, state_wr, preset_wr;
   logic [CNT_W-1:0] preset_q;
   logic pwroff_q, tblong_q;

   assign ctrl_wr   = wr_i && (addr_i == REG_CTRL);
   assign state_wr  = wr_i && (addr_i == REG_STATE);
   assign preset_wr = wr_i && (addr_i == REG_PRESET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preset_q <= '0;
         pwroff_q <= 1'b0;
         tblong_q <= 1'b0;
      end else begin
         if (preset_wr) preset_q <= wdata_i[CNT_W-1:0];
         if (ctrl_wr) begin
            pwroff_q <= wdata_i[CTRL_PWROFF];
            tblong_q <= wdata_i[CTRL_TBLONG];
         end
      end
   end

   assign cmd_stop_o  = ctrl_wr && wdata_i[CTRL_STOP];
   assign cmd_start_o = ctrl_wr && wdata_i[CTRL_START];
   assign flag_clr_o  = state_wr && wdata_i[STATE_FLAG];
   assign preset_o    = preset_q;
   assign pwroff_en_o = pwroff_q;
   assign tb_long_o   = tblong_q;

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         REG_CTRL: begin
            rdata_o[CTRL_PWROFF] = pwroff_q;
            rdata_o[CTRL_TBLONG] = tblong_q;
            rdata_o[CTRL_START]  = armed_i;
         end
         REG_STATE:  rdata_o[STATE_FLAG] = flag_i;
         REG_PRESET: rdata_o[CNT_W-1:0]  = preset_q;
         default:    rdata_o = '0;
      endcase
   end

   // R2: a preset write is visible on the next cycle
   assert_preset_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      preset_wr |=> (preset_q == $past(wdata_i[CNT_W-1:0])));
endmodule

// File: rtl/smwd_counter.sv
module smwd_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start_i,
   input  logic             cmd_stop_i,
   input  logic [CNT_W-1:0] preset_i,
   input  logic             tb_long_i,
   input  logic             tick_short_i,
   input  logic             tick_long_i,
   output logic             armed_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             armed_q;
   logic [CNT_W-1:0] count_q;
   logic             tick_sel, cmd_any;

   generate
      if (CNT_W == 1) begin : g_narrow
         assign tick_sel = tb_long_i ? tick_long_i : tick_short_i;
      end else begin : g_wide
         logic [1:0] ticks;
         assign ticks    = {tick_long_i, tick_short_i};
         assign tick_sel = ticks[tb_long_i];
      end
   endgenerate

   assign cmd_any  = cmd_start_i || cmd_stop_i;
   assign expire_o = armed_q && tick_sel && !cmd_any && (count_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         count_q <= '0;
      end else if (cmd_stop_i) begin
         armed_q <= 1'b0;
      end else if (cmd_start_i) begin
         armed_q <= 1'b1;
         count_q <= preset_i;
      end else if (expire_o) begin
         armed_q <= 1'b0;
         count_q <= '0;
      end else if (armed_q && tick_sel) begin
         count_q <= count_q - ONE;
      end
   end

   assign armed_o = armed_q;

   assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop_i |=> !armed_q);
   assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start_i && !cmd_stop_i) |=> (armed_q && count_q == $past(preset_i)));
   assert_expire_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !armed_q);
   assert_idle_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !cmd_start_i) |=> (!armed_q && $stable(count_q)));
endmodule

// File: rtl/smwd_action.sv
module smwd_action #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic pwroff_en_i,
   input  logic thermal_i,
   input  logic flag_clr_i,
   output logic sys_rst_o,
   output logic power_off_o,
   output logic flag_o
);
   localparam int RC_W = $clog2(RST_CYCLES + 1);

   logic choose_off, do_reset;
   logic off_q, flag_q;

   assign choose_off = pwroff_en_i && thermal_i;
   assign do_reset   = expire_i && !choose_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (expire_i && choose_off) off_q <= 1'b1;
         if (expire_i)               flag_q <= 1'b1;
         else if (flag_clr_i)        flag_q <= 1'b0;
      end
   end

   generate
      if (RST_CYCLES == 1) begin : g_single
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= do_reset;
         end
         assign sys_rst_o = pulse_q;
      end else begin : g_count
         logic [RC_W-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= '0;
            else if (do_reset)       left_q <= RC_W'(RST_CYCLES);
            else if (left_q != '0)   left_q <= left_q - RC_W'(1);
         end
         assign sys_rst_o = (left_q != '0);
      end
   endgenerate

   assign power_off_o = off_q;
   assign flag_o      = flag_q;

   assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && !choose_off) |=> sys_rst_o);
   assert_power_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && choose_off) |=> power_off_o);
   assert_power_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      power_off_o |=> power_off_o);
   assert_no_pulse_on_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i && choose_off && !sys_rst_o) |=> !sys_rst_o);
   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !expire_i) |=> !flag_o);
   assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i |=> flag_o);
endmodule

// File: rtl/smwd_top.sv
module smwd_top
   import smwd_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              tick_short_i,
   input  logic              tick_long_i,
   input  logic              thermal_i,
   output logic              sys_rst_o,
   output logic              power_off_o,
   output logic              wd_alarm_o
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("smwd_top: CNT_W must lie in 1..DATA_W");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("smwd_top: RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] preset;
   logic pwroff_en, tb_long, cmd_start, cmd_stop, flag_clr;
   logic armed, expire, flag;

   smwd_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .armed_i(armed), .flag_i(flag),
      .preset_o(preset), .pwroff_en_o(pwroff_en), .tb_long_o(tb_long),
      .cmd_start_o(cmd_start), .cmd_stop_o(cmd_stop), .flag_clr_o(flag_clr),
      .rdata_o(reg_rdata_o)
   );

   smwd_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n),
      .cmd_start_i(cmd_start), .cmd_stop_i(cmd_stop),
      .preset_i(preset), .tb_long_i(tb_long),
      .tick_short_i(tick_short_i), .tick_long_i(tick_long_i),
      .armed_o(armed), .expire_o(expire)
   );

   smwd_action #(.RST_CYCLES(RST_CYCLES)) u_action (
      .clk(clk), .rst_n(rst_n),
      .expire_i(expire), .pwroff_en_i(pwroff_en), .thermal_i(thermal_i),
      .flag_clr_i(flag_clr),
      .sys_rst_o(sys_rst_o), .power_off_o(power_off_o), .flag_o(flag)
   );

   assign wd_alarm_o = flag;

   // R1: nothing is asserted right after reset
   assert_quiet_after_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!sys_rst_o && !power_off_o && !wd_alarm_o));
endmodule

// File: tb/test_smwd_top.sv
`timescale 1ns/1ps
module test_smwd_top;
   localparam int RSTC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic tks = 1'b0, tkl = 1'b0, therm = 1'b0;
   logic srst, poff, alarm;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   smwd_top #(.CNT_W(8), .RST_CYCLES(RSTC)) i_smwd_top (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .tick_short_i(tks), .tick_long_i(tkl), .thermal_i(therm),
      .sys_rst_o(srst), .power_off_o(poff), .wd_alarm_o(alarm)
   );

   function automatic int ticks_to_expire(input int p);
      return (p == 0) ? 1 : p;
   endfunction
   function automatic bit takes_power_off(input bit pen, input bit th);
      return pen && th;
   endfunction

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1; wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [7:0] d);
      addr = a; #0.5; d = rdata;
   endtask

   // one tick of the chosen timebase; returns shortly after the consuming edge
   task automatic tick(input bit long_tb);
      @(negedge clk);
      if (long_tb) tkl = 1'b1; else tks = 1'b1;
      @(posedge clk); #1; tkl = 1'b0; tks = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // count how long sys_rst stays high, starting in a cycle where it is high
   task automatic pulse_len(output int len);
      len = 0;
      while (srst && len < 50) begin
         len++;
         @(posedge clk); #1;
      end
   endtask

   task automatic run_case(input int p, input bit tb, input bit pen, input bit th,
                           input bit stray);
      logic [7:0] r;
      int n, len;
      n = ticks_to_expire(p);
      therm = th;
      wreg(2'd2, 8'(p));
      wreg(2'd0, {pen, tb, 2'b01, 4'b0000});
      for (int i = 1; i <= n; i++) begin
         if (stray && ($urandom % 2 == 1)) begin
            tick(!tb);
            chk(srst | poff | alarm, 0, "R5 wrong timebase tick counted");
         end
         tick(tb);
         if (i < n) begin
            chk(srst | alarm, 0, "R6 early expiry");
         end
      end
      rreg(2'd0, r);
      chk(r[4], 0, "R7 armed after expiry");
      chk(alarm, 1, "R10 alarm after expiry");
      if (takes_power_off(pen, th)) begin
         chk(poff, 1, "R9 power off");
         chk(srst, 0, "R9 reset pulse with power off");
      end else begin
         chk(poff, 0, "R8 power off without thermal option");
         pulse_len(len);
         chk(len, RSTC, "R8 reset pulse length");
      end
      tick(tb); tick(tb);
      chk(srst, 0, "R7 new expiry while disarmed");
      wreg(2'd1, 8'h02);
      chk(alarm, 0, "R10 flag clear");
      if (poff) begin
         do_reset();
         #1;
         chk(poff, 0, "R9 power off cleared by hardware reset");
      end
      therm = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      int len;
      int seed_v;
      seed_v = $urandom(32'd20240611);

      // R1 reset state
      #12; rst_n = 1'b1; #1;
      rreg(2'd0, r); chk(r, 0, "R1 control after reset");
      rreg(2'd1, r); chk(r, 0, "R1 state after reset");
      rreg(2'd2, r); chk(r, 0, "R1 preset after reset");
      chk({srst, poff, alarm}, 0, "R1 outputs after reset");

      // R2 preset storage
      wreg(2'd2, 8'hA5); rreg(2'd2, r); chk(r, 8'hA5, "R2 preset A5");
      wreg(2'd2, 8'h3C); rreg(2'd2, r); chk(r, 8'h3C, "R2 preset 3C");

      // R3 control readback
      wreg(2'd0, 8'hC0); rreg(2'd0, r); chk(r, 8'hC0, "R3 options readback");
      wreg(2'd0, 8'h10); rreg(2'd0, r); chk(r, 8'h10, "R3 armed readback");
      // R4 disarm, and priority over arm
      wreg(2'd0, 8'h20); rreg(2'd0, r); chk(r, 8'h00, "R4 disarm");
      wreg(2'd0, 8'h10);
      wreg(2'd0, 8'h30); rreg(2'd0, r); chk(r, 8'h00, "R4 disarm wins over arm");
      wreg(2'd2, 8'h01);
      tick(1'b0); tick(1'b0); tick(1'b0);
      chk({srst, alarm}, 0, "R4 disarmed ignores ticks");

      // R6 re-arm reloads the full count
      wreg(2'd2, 8'h03);
      wreg(2'd0, 8'h10);
      tick(1'b0); tick(1'b0);
      wreg(2'd0, 8'h10);
      tick(1'b0); tick(1'b0);
      chk(alarm, 0, "R6 re-arm restarts count");
      tick(1'b0);
      chk(alarm, 1, "R6 expiry after re-arm");
      chk(srst, 1, "R8 pulse after re-arm expiry");
      pulse_len(len);
      // R10 write with bit1 clear keeps flag
      wreg(2'd1, 8'hFD);
      rreg(2'd1, r); chk(r, 8'h02, "R10 flag kept on write of 0");
      wreg(2'd1, 8'h02);
      rreg(2'd1, r); chk(r, 8'h00, "R10 flag cleared");

      // R5 long timebase ignores short ticks
      wreg(2'd2, 8'h02);
      wreg(2'd0, 8'h50);
      tick(1'b0); tick(1'b0); tick(1'b0);
      chk(alarm, 0, "R5 short ticks on long timebase");
      wreg(2'd0, 8'h20);

      // directed corners
      run_case(0, 1'b0, 1'b0, 1'b0, 1'b0);   // R6 zero preset
      run_case(2, 1'b1, 1'b1, 1'b1, 1'b0);   // R9 power off
      run_case(1, 1'b0, 1'b1, 1'b0, 1'b0);   // R8 option set, no thermal
      run_case(3, 1'b1, 1'b0, 1'b1, 1'b0);   // R8 thermal, option clear

      // constrained random sessions
      for (int k = 0; k < 40; k++) begin
         run_case(int'($urandom % 6), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
      end

      finish_run();
   end
endmodule